// File: doc/BRIEF.md
# Second-Order Fixed-Point Lowpass Filter Section

This block is one biquad lowpass stage for an 8 kHz tone-receiver front end. It has a Butterworth response with its corner near 852 Hz, and it reaches at least 15 dB of rejection by 2 kHz. It uses the direct-form-II arrangement. One intermediate node `w` is computed from the new input and two stored past values of `w`. The output is a weighted sum of the new `w` and the same two stored values, so a single two-word delay line serves both the recursive half and the non-recursive half.

Input and output samples are signed Q1.15 fractions. The coefficients are Q2.14 constants fixed at elaboration time, because the first feedback term has a magnitude above one. The stored `w` values are Q3.15 (18 bits). At DC the recursive half alone has a gain of about 3.3, and the extra integer bits absorb it. Each sum is formed in a wide accumulator, rounded to nearest and saturated before it is stored or presented.

A sample is taken on a clock where `in_valid` is high. The filtered value appears on the next clock, marked by `out_valid`.

Top module: `iir_lp2_df2`

## Requirements
- R1: On each accepted sample, the new node value is w = sat18(round((x*16384 + 17863*w1 - 6392*w2) / 2^14)). Here x is the Q1.15 input, w1 and w2 are the previous and second-previous node values (Q3.15, 18-bit signed), and the Q2.14 coefficients are a1 = -17863 and a2 = 6392.
- R2: The output is y = sat16(round((1228*w + 2456*w1 + 1228*w2) / 2^14)), where w is the node value from R1 for the same sample and w1, w2 are the stored values before the update.
- R3: Rounding adds 2^13 to the full-precision sum and then shifts right by 14 with sign extension. This is round-half-up: an input of +1 alone gives w = 1, and -1 alone gives w = -1.
- R4: A node value outside [-131072, 131071] is clamped to that bound, and an output outside [-32768, 32767] is clamped to that bound. Neither wraps.
- R5: `out_valid` is high in exactly the clock after a clock with `in_valid` high, and low otherwise.
- R6: While `in_valid` is low, the stored node values and `out_sample` keep their values.
- R7: A synchronous active-high `rst` clears both stored node values, `out_sample` and `out_valid` to zero. The next output then comes from a filter starting at rest.
- R8: With a constant input of 32767, the output settles to within 8 LSB of 32760, which is the DC gain 4912/4913 times the input, with no node saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_sample` this clock |
| in_sample | input | 16 | Signed Q1.15 input sample |
| out_valid | output | 1 | One-clock pulse marking a new output |
| out_sample | output | 16 | Signed Q1.15 filtered sample |

## Verification
A wrong stored node value is not hidden by the output stage. Both stored words feed the output sum directly, so the error appears in `out_sample` on the very next accepted sample. It then persists and rings through the feedback for many samples. A rounding or clamping slip shows up first as a one-LSB or bound mismatch against a bit-exact integer recurrence. The full-scale negative-to-positive step is chosen to overshoot and hit the output clamp. A long DC run exposes a drifting gain or a node that overflows instead of holding its headroom.

// File: rtl/iir_lp2_pkg.sv
package iir_lp2_pkg;
  // Number of terms in each three-tap sum
  localparam int unsigned NTAP = 3;
endpackage

// File: rtl/iir_mac_rs.sv
// Multi-term signed multiply-accumulate with round-half-up and saturation.
module iir_mac_rs #(
  parameter int unsigned NT   = 3,
  parameter int unsigned CW   = 16,
  parameter int unsigned DW   = 18,
  parameter int unsigned FRAC = 14,
  parameter int unsigned OW   = 18
) (
  input  logic [NT-1:0][CW-1:0] coef_i,
  input  logic [NT-1:0][DW-1:0] data_i,
  output logic [OW-1:0]         result_o
);
  localparam int unsigned PW = CW + DW;
  localparam int unsigned AW = PW + $clog2(NT) + 4;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [AW-1:0] prod [NT];
  logic signed [AW-1:0] acc, shifted;

  for (genvar t = 0; t < NT; t++) begin : g_term
    assign prod[t] = AW'($signed(coef_i[t])) * AW'($signed(data_i[t]));
  end

  always_comb begin
    acc = HALF;
    for (int t = 0; t < NT; t++) acc = acc + prod[t];
    shifted = acc >>> FRAC;
    if (shifted > MAXV)      result_o = MAXV[OW-1:0];
    else if (shifted < MINV) result_o = MINV[OW-1:0];
    else                     result_o = shifted[OW-1:0];
  end
endmodule

// File: rtl/iir_dline.sv
// Shared two-word delay line plus the registered output stage.
module iir_dline #(
  parameter int unsigned SW = 18,
  parameter int unsigned OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic [SW-1:0] w_new_i,
  input  logic [OW-1:0] y_new_i,
  output logic [SW-1:0] w1_o,
  output logic [SW-1:0] w2_o,
  output logic [OW-1:0] y_o,
  output logic          valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w1_o    <= '0;
      w2_o    <= '0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= adv_i;
      if (adv_i) begin
        w1_o <= w_new_i;
        w2_o <= w1_o;
        y_o  <= y_new_i;
      end
    end
  end

  // R5
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> valid_o);
  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> !valid_o);
  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(w1_o) && $stable(w2_o) && $stable(y_o)));
  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (w2_o == $past(w1_o)));
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && w1_o == '0 && w2_o == '0 && y_o == '0));
endmodule

// File: rtl/iir_lp2_df2.sv
module iir_lp2_df2
  import iir_lp2_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned SW    = 18,
  parameter int unsigned CW    = 16,
  parameter int unsigned CFRAC = 14,
  parameter int          B0    = 1228,
  parameter int          B1    = 2456,
  parameter int          B2    = 1228,
  parameter int          A1    = -17863,
  parameter int          A2    = 6392
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  localparam logic [CW-1:0] C_ONE = CW'(1 << CFRAC);
  localparam logic [CW-1:0] C_NA1 = CW'(-A1);
  localparam logic [CW-1:0] C_NA2 = CW'(-A2);

  logic [SW-1:0] w1, w2, w_new;
  logic [DW-1:0] y_new;
  logic [NTAP-1:0][CW-1:0] fb_coef, ff_coef;
  logic [NTAP-1:0][SW-1:0] fb_data, ff_data;

  assign fb_coef = {C_NA2, C_NA1, C_ONE};
  assign fb_data = {w2, w1, SW'($signed(in_sample))};
  assign ff_coef = {CW'(B2), CW'(B1), CW'(B0)};
  assign ff_data = {w2, w1, w_new};

  iir_mac_rs #(.NT(NTAP), .CW(CW), .DW(SW), .FRAC(CFRAC), .OW(SW)) u_fb (
    .coef_i(fb_coef), .data_i(fb_data), .result_o(w_new));

  iir_mac_rs #(.NT(NTAP), .CW(CW), .DW(SW), .FRAC(CFRAC), .OW(DW)) u_ff (
    .coef_i(ff_coef), .data_i(ff_data), .result_o(y_new));

  iir_dline #(.SW(SW), .OW(DW)) u_dline (
    .clk(clk), .rst(rst), .adv_i(in_valid), .w_new_i(w_new), .y_new_i(y_new),
    .w1_o(w1), .w2_o(w2), .y_o(out_sample), .valid_o(out_valid));

  // R4
  out_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $signed(w_new) == $signed({1'b0, {(SW-1){1'b1}}})) |=>
      ($signed(w1) > 0));
endmodule

// File: tb/iir_lp2_df2_bench.sv
module iir_lp2_df2_bench;
  localparam int PERIOD = 10;
  localparam int NV = 16;
  localparam logic signed [15:0] STIM [NV] = '{
    16'sd1, -16'sd1, 16'sd0, 16'sd16384, 16'sd16384, -16'sd20000, 16'sd3000,
    16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd100, -16'sd7,
    16'sd12345, 16'sd0, 16'sd0};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [15:0] in_sample = '0;
  logic out_valid;
  logic [15:0] out_sample;
  int checks = 0, fails = 0;
  longint mw1 = 0, mw2 = 0;

  always #(PERIOD/2) clk = ~clk;

  iir_lp2_df2 u_iir_lp2_df2 (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample));

  function automatic longint sat(longint v, longint lim);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // Bit-exact recurrence from R1..R4
  function automatic longint model_step(longint x);
    longint w, y;
    w = sat((x * 16384 + 17863 * mw1 - 6392 * mw2 + 8192) >>> 14, 131072);
    y = sat((1228 * w + 2456 * mw1 + 1228 * mw2 + 8192) >>> 14, 32768);
    mw2 = mw1;
    mw1 = w;
    return y;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1; in_valid = 0;
    @(negedge clk); @(negedge clk) rst = 0;
    mw1 = 0; mw2 = 0;
  endtask

  // Accept one sample, sample the result at the following falling edge
  task automatic send(longint x, output longint got, output longint exp);
    @(negedge clk) in_sample = 16'(x); in_valid = 1;
    exp = model_step(x);
    @(negedge clk) in_valid = 0;
    got = longint'($signed(out_sample));
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint got, exp, held;
    int clipped;
    do_reset();
    check("R7 reset out_valid", out_valid, 0);
    check("R7 reset out_sample", $signed(out_sample), 0);

    // R3 rounding of a lone +1 and then -1
    send(1, got, exp);
    check("R3 +1 node", mw1, 1);
    check("R3 +1 output", got, 0);
    check("R5 out_valid after accept", out_valid, 1);
    @(negedge clk);
    check("R5 out_valid idle", out_valid, 0);
    do_reset();
    send(-1, got, exp);
    check("R3 -1 node", mw1, -1);

    // R1 R2 table walk
    do_reset();
    for (int i = 0; i < NV; i++) begin
      send(STIM[i], got, exp);
      check("R1 R2 table", got, exp);
    end

    // R6 hold while in_valid low
    held = longint'($signed(out_sample));
    in_sample = 16'h7fff;
    repeat (5) @(negedge clk);
    check("R6 out_sample held", $signed(out_sample), held);
    send(0, got, exp);
    check("R6 state held", got, exp);

    // R4 full-scale step overshoots into the output clamp
    do_reset();
    clipped = 0;
    for (int i = 0; i < 40; i++) begin
      send(-32768, got, exp);
      check("R4 negative rail", got, exp);
    end
    for (int i = 0; i < 40; i++) begin
      send(32767, got, exp);
      check("R4 step", got, exp);
      if (got == 32767) clipped++;
    end
    check("R4 clamp reached", clipped > 0, 1);

    // R8 DC settling
    do_reset();
    for (int i = 0; i < 120; i++) send(32767, got, exp);
    check("R8 dc settle", (got >= 32752 && got <= 32767), 1);
    check("R8 node below rail", mw1 < 131071, 1);

    // R7 reset mid-run, filter restarts at rest
    do_reset();
    check("R7 reset mid-run", $signed(out_sample), 0);
    send(20000, got, exp);
    check("R7 fresh start", got, exp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule